// File: doc/BRIEF.md
# Data Access Address Translator and Permission Checker

This block sits in the load/store path of a processor core. For every data access it turns a virtual address into a physical address and decides whether the access must trap. The address can come from one of three sources. In physical mode the virtual address is used unchanged. A fixed kernel-only direct-mapped window is selected by the upper virtual address bits. Otherwise the address comes from a page lookup, whose result (hit, page frame number, per-mode read and write enables, and the fault-on-read and fault-on-write bits) is supplied by an external lookup array.

Each request is captured on a strobe. Exactly one cycle later the block presents the physical address, a fault kind, a small vector of memory-status flags and an uncacheable indication. At the same time it emits one-cycle event pulses that external counters can use to tally read and write hits, misses and violations. Faults are ranked in a fixed order: alignment, then window privilege, then page miss, then permission, then fault-on bits, then physical range.

Top module: `data_xlate_chk`

## Requirements
- R1: `valid_o` is high in exactly the cycle after a cycle in which `req_i` was sampled high. All result outputs belong to that request. `valid_o` is low after reset and whenever no request was sampled.
- R2: The alignment check has top priority. If any VA bit below 2^`size_i` bytes is set (`size_i` is log2 of the byte count, 0..3), the fault kind is 1. Status bit 0 (write) equals `write_i`, and no other status bit is set. This also holds in physical mode.
- R3: The mode used for page permission is `alt_mode_i` when `priv_pc_i` and `alt_sel_i` are both set. It is kernel (0) when `priv_pc_i` is set and `alt_sel_i` is clear. Otherwise it is `cur_mode_i`. Modes are 0 kernel, 1 executive, 2 supervisor, 3 user.
- R4: With `phys_i` set, the PA equals the VA and the page lookup inputs have no effect: no miss, no violation and no event pulse.
- R5: A non-physical access with VA[47:41] = 7'h7E uses the direct window. If `cur_mode_i` is not kernel, this gives fault kind 2 with status bit 1 (violation) and status bit 0 equal to `write_i`. The alternate mode plays no part in this check.
- R6: A window access takes VA[43:0] as its PA. If VA[40] is set, PA[43:40] are forced to ones; otherwise PA[43:40] are cleared.
- R7: A page access without a hit gives fault kind 4 when `pte_fetch_i` is set and kind 3 otherwise. Status bit 2 (miss) is set, and bit 0 equals `write_i`.
- R8: On a hit, the PA is {`tlb_ppn_i`, VA[12:0]}. The enable bit for the effective mode in `tlb_wr_en_i` (for writes) or `tlb_rd_en_i` (for reads) must be set. If it is not, the fault kind is 2 with status bit 1 set, bit 0 equal to `write_i`, and bit 4 (for writes) or bit 3 (for reads) copying the corresponding fault-on input.
- R9: A permitted page access whose fault-on bit (`tlb_fonw_i` for writes, `tlb_fonr_i` for reads) is set gives fault kind 5. Only status bit 4 or 3 is set, plus bit 0 for writes.
- R10: An access with no other fault whose formed address has any bit at or above bit 44 set gives fault kind 6 with an all-zero status.
- R11: When the formed PA has bit 43 set and no fault is raised, `uncached_o` is high and PA[42:35] are returned as zero.
- R12: Exactly one of the six event outputs pulses, together with `valid_o`, for each of these cases: a page hit with permission and no fault-on bit (counted even when R10 then applies), a page miss, or a kind 2 or kind 5 fault. The pulse goes to the read or the write group according to `write_i`. No event pulses in any other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, one access per cycle |
| va_i | input | 64 | Virtual address |
| size_i | input | 2 | log2 of access size in bytes |
| write_i | input | 1 | Access is a store |
| phys_i | input | 1 | Physical-mode access, bypass translation |
| alt_sel_i | input | 1 | Use alternate mode when PC is privileged |
| priv_pc_i | input | 1 | Access issued from privileged code |
| pte_fetch_i | input | 1 | Access is a page-table-entry fetch |
| cur_mode_i | input | 2 | Current processor mode |
| alt_mode_i | input | 2 | Alternate processor mode |
| tlb_hit_i | input | 1 | Page lookup hit |
| tlb_ppn_i | input | 32 | Page frame number from lookup |
| tlb_rd_en_i | input | 4 | Per-mode read enables |
| tlb_wr_en_i | input | 4 | Per-mode write enables |
| tlb_fonr_i | input | 1 | Fault-on-read page bit |
| tlb_fonw_i | input | 1 | Fault-on-write page bit |
| valid_o | output | 1 | Result valid |
| pa_o | output | 44 | Physical address |
| fault_o | output | 3 | Fault kind: 0 none, 1 align, 2 violation, 3 miss, 4 PTE miss, 5 fault-on, 6 machine check |
| status_o | output | 5 | Status flags: 0 write, 1 violation, 2 miss, 3 fault-on-read, 4 fault-on-write |
| uncached_o | output | 1 | Access targets uncacheable space |
| ev_rd_hit_o | output | 1 | Read hit pulse |
| ev_rd_miss_o | output | 1 | Read miss pulse |
| ev_rd_viol_o | output | 1 | Read violation pulse |
| ev_wr_hit_o | output | 1 | Write hit pulse |
| ev_wr_miss_o | output | 1 | Write miss pulse |
| ev_wr_viol_o | output | 1 | Write violation pulse |

## Verification
Every result is due one clock edge after its request strobe, because the translation is combinational into a single output register. The bench drives each vector just after a falling edge, lets one rising edge capture it, and samples at the next falling edge, with vectors issued back to back. After the last request it drops the strobe and checks one cycle later that `valid_o` and all event pulses have returned low. This confirms that the pulses last a single cycle and that idle cycles produce no results.

// File: rtl/dx_pkg.sv
package dx_pkg;

  typedef enum logic [2:0] {
    FK_NONE     = 3'd0,
    FK_ALIGN    = 3'd1,
    FK_ACV      = 3'd2,
    FK_MISS     = 3'd3,
    FK_PTE_MISS = 3'd4,
    FK_FON      = 3'd5,
    FK_MCHK     = 3'd6
  } fault_e;

  typedef enum logic [1:0] {
    MD_KERN = 2'd0,
    MD_EXEC = 2'd1,
    MD_SUPV = 2'd2,
    MD_USER = 2'd3
  } mode_e;

  localparam int ST_W    = 5;
  localparam int ST_WR   = 0;
  localparam int ST_ACV  = 1;
  localparam int ST_MISS = 2;
  localparam int ST_FONR = 3;
  localparam int ST_FONW = 4;

  typedef struct packed {
    logic rd_hit;
    logic rd_miss;
    logic rd_viol;
    logic wr_hit;
    logic wr_miss;
    logic wr_viol;
  } evt_t;

endpackage

// File: rtl/dx_mode_sel.sv
module dx_mode_sel #(
  parameter int MODE_W = 2
) (
  input  logic              priv_pc_i,
  input  logic              alt_sel_i,
  input  logic [MODE_W-1:0] cur_mode_i,
  input  logic [MODE_W-1:0] alt_mode_i,
  output logic [MODE_W-1:0] eff_mode_o
);
  // Privileged code runs in kernel unless it asks for the alternate mode.
  always_comb begin
    if (priv_pc_i) begin
      eff_mode_o = alt_sel_i ? alt_mode_i : MODE_W'(dx_pkg::MD_KERN);
    end else begin
      eff_mode_o = cur_mode_i;
    end
  end
endmodule

// File: rtl/dx_addr_form.sv
module dx_addr_form #(
  parameter int VA_W       = 64,
  parameter int PA_W       = 44,
  parameter int PPN_W      = 32,
  parameter int PAGE_SHIFT = 13,
  parameter int SP_HI      = 47,
  parameter int SP_LO      = 41,
  parameter int SP_TAG     = 'h7e,
  parameter int SIGN_BIT   = 40,
  parameter int UNC_BIT    = 43,
  parameter int CLR_HI     = 42,
  parameter int CLR_LO     = 35
) (
  input  logic [VA_W-1:0]  va_i,
  input  logic             phys_i,
  input  logic [PPN_W-1:0] ppn_i,
  output logic             super_o,
  output logic [PA_W-1:0]  pa_o,
  output logic             mchk_o,
  output logic             unc_o
);
  localparam int SP_W  = SP_HI - SP_LO + 1;
  localparam int TLB_W = PPN_W + PAGE_SHIFT;

  logic [VA_W-1:0] sp_raw;
  logic [VA_W-1:0] tlb_raw;
  logic [VA_W-1:0] raw;

  assign super_o = !phys_i && (va_i[SP_HI:SP_LO] == SP_W'(SP_TAG));

  // Direct window: keep implemented bits, then extend from the sign bit.
  always_comb begin
    sp_raw = '0;
    sp_raw[PA_W-1:0] = va_i[PA_W-1:0];
    if (va_i[SIGN_BIT]) sp_raw[PA_W-1:SIGN_BIT] = '1;
    else                sp_raw[PA_W-1:SIGN_BIT] = '0;
  end

  always_comb begin
    tlb_raw = '0;
    tlb_raw[TLB_W-1:0] = {ppn_i, va_i[PAGE_SHIFT-1:0]};
  end

  always_comb begin
    if (phys_i)       raw = va_i;
    else if (super_o) raw = sp_raw;
    else              raw = tlb_raw;
  end

  assign mchk_o = |raw[VA_W-1:PA_W];
  assign unc_o  = raw[UNC_BIT];

  // Uncacheable space drops the routing field bits.
  for (genvar b = 0; b < PA_W; b++) begin : g_pa
    if (b >= CLR_LO && b <= CLR_HI) begin : g_clr
      assign pa_o[b] = raw[b] & ~unc_o;
    end else begin : g_keep
      assign pa_o[b] = raw[b];
    end
  end
endmodule

// File: rtl/dx_fault_dec.sv
module dx_fault_dec #(
  parameter int SZ_W   = 2,
  parameter int MODE_N = 4,
  parameter int MODE_W = 2
) (
  input  logic [(1<<SZ_W)-2:0] va_low_i,
  input  logic [SZ_W-1:0]      size_i,
  input  logic                 write_i,
  input  logic                 phys_i,
  input  logic                 super_i,
  input  logic [MODE_W-1:0]    cur_mode_i,
  input  logic [MODE_W-1:0]    eff_mode_i,
  input  logic                 hit_i,
  input  logic                 pte_i,
  input  logic [MODE_N-1:0]    rd_en_i,
  input  logic [MODE_N-1:0]    wr_en_i,
  input  logic                 fonr_i,
  input  logic                 fonw_i,
  input  logic                 mchk_i,
  output dx_pkg::fault_e       kind_o,
  output logic [dx_pkg::ST_W-1:0] st_o,
  output dx_pkg::evt_t         ev_o
);
  import dx_pkg::*;

  localparam int LOW_W = (1 << SZ_W) - 1;

  logic [LOW_W:0]   size_one;
  logic [LOW_W-1:0] low_mask;
  logic             align_bad;
  logic             perm;
  logic             fon;
  logic             tlb_path;
  logic             viol;

  assign size_one  = (LOW_W+1)'(1) << size_i;
  assign low_mask  = size_one[LOW_W-1:0] - LOW_W'(1);
  assign align_bad = |(va_low_i & low_mask);
  assign perm      = write_i ? wr_en_i[eff_mode_i] : rd_en_i[eff_mode_i];
  assign fon       = write_i ? fonw_i : fonr_i;
  assign tlb_path  = !align_bad && !phys_i && !super_i;

  always_comb begin
    kind_o = FK_NONE;
    st_o   = '0;
    if (align_bad) begin
      kind_o       = FK_ALIGN;
      st_o[ST_WR]  = write_i;
    end else if (phys_i) begin
      kind_o = FK_NONE;
    end else if (super_i) begin
      if (cur_mode_i != MODE_W'(MD_KERN)) begin
        kind_o       = FK_ACV;
        st_o[ST_WR]  = write_i;
        st_o[ST_ACV] = 1'b1;
      end
    end else if (!hit_i) begin
      kind_o        = pte_i ? FK_PTE_MISS : FK_MISS;
      st_o[ST_WR]   = write_i;
      st_o[ST_MISS] = 1'b1;
    end else if (!perm) begin
      kind_o        = FK_ACV;
      st_o[ST_WR]   = write_i;
      st_o[ST_ACV]  = 1'b1;
      st_o[ST_FONW] = write_i & fonw_i;
      st_o[ST_FONR] = !write_i & fonr_i;
    end else if (fon) begin
      kind_o        = FK_FON;
      st_o[ST_WR]   = write_i;
      st_o[ST_FONW] = write_i;
      st_o[ST_FONR] = !write_i;
    end
    if (kind_o == FK_NONE && mchk_i) begin
      kind_o = FK_MCHK;
      st_o   = '0;
    end
  end

  assign viol = (kind_o == FK_ACV) || (kind_o == FK_FON);

  always_comb begin
    ev_o         = '0;
    ev_o.rd_hit  = tlb_path && hit_i && perm && !fon && !write_i;
    ev_o.wr_hit  = tlb_path && hit_i && perm && !fon && write_i;
    ev_o.rd_miss = tlb_path && !hit_i && !write_i;
    ev_o.wr_miss = tlb_path && !hit_i && write_i;
    ev_o.rd_viol = viol && !write_i;
    ev_o.wr_viol = viol && write_i;
  end
endmodule

// File: rtl/data_xlate_chk.sv
module data_xlate_chk #(
  parameter int VA_W       = 64,
  parameter int PA_W       = 44,
  parameter int PPN_W      = 32,
  parameter int PAGE_SHIFT = 13,
  parameter int SZ_W       = 2,
  parameter int MODE_N     = 4,
  parameter int SP_HI      = 47,
  parameter int SP_LO      = 41,
  parameter int SP_TAG     = 'h7e,
  parameter int SIGN_BIT   = 40,
  parameter int UNC_BIT    = 43,
  parameter int CLR_HI     = 42,
  parameter int CLR_LO     = 35
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic              write_i,
  input  logic              phys_i,
  input  logic              alt_sel_i,
  input  logic              priv_pc_i,
  input  logic              pte_fetch_i,
  input  logic [1:0]        cur_mode_i,
  input  logic [1:0]        alt_mode_i,
  input  logic              tlb_hit_i,
  input  logic [PPN_W-1:0]  tlb_ppn_i,
  input  logic [MODE_N-1:0] tlb_rd_en_i,
  input  logic [MODE_N-1:0] tlb_wr_en_i,
  input  logic              tlb_fonr_i,
  input  logic              tlb_fonw_i,
  output logic              valid_o,
  output logic [PA_W-1:0]   pa_o,
  output logic [2:0]        fault_o,
  output logic [4:0]        status_o,
  output logic              uncached_o,
  output logic              ev_rd_hit_o,
  output logic              ev_rd_miss_o,
  output logic              ev_rd_viol_o,
  output logic              ev_wr_hit_o,
  output logic              ev_wr_miss_o,
  output logic              ev_wr_viol_o
);
  import dx_pkg::*;

  localparam int MODE_W = $clog2(MODE_N);
  localparam int LOW_W  = (1 << SZ_W) - 1;

  logic [MODE_W-1:0] eff_mode;
  logic              is_super;
  logic [PA_W-1:0]   pa_c;
  logic              mchk_c;
  logic              unc_c;
  fault_e            kind_c;
  logic [ST_W-1:0]   st_c;
  evt_t              ev_c;

  dx_mode_sel #(.MODE_W(MODE_W)) u_mode (
    .priv_pc_i (priv_pc_i),
    .alt_sel_i (alt_sel_i),
    .cur_mode_i(cur_mode_i),
    .alt_mode_i(alt_mode_i),
    .eff_mode_o(eff_mode)
  );

  dx_addr_form #(
    .VA_W(VA_W), .PA_W(PA_W), .PPN_W(PPN_W), .PAGE_SHIFT(PAGE_SHIFT),
    .SP_HI(SP_HI), .SP_LO(SP_LO), .SP_TAG(SP_TAG), .SIGN_BIT(SIGN_BIT),
    .UNC_BIT(UNC_BIT), .CLR_HI(CLR_HI), .CLR_LO(CLR_LO)
  ) u_addr (
    .va_i   (va_i),
    .phys_i (phys_i),
    .ppn_i  (tlb_ppn_i),
    .super_o(is_super),
    .pa_o   (pa_c),
    .mchk_o (mchk_c),
    .unc_o  (unc_c)
  );

  dx_fault_dec #(.SZ_W(SZ_W), .MODE_N(MODE_N), .MODE_W(MODE_W)) u_fault (
    .va_low_i  (va_i[LOW_W-1:0]),
    .size_i    (size_i),
    .write_i   (write_i),
    .phys_i    (phys_i),
    .super_i   (is_super),
    .cur_mode_i(cur_mode_i),
    .eff_mode_i(eff_mode),
    .hit_i     (tlb_hit_i),
    .pte_i     (pte_fetch_i),
    .rd_en_i   (tlb_rd_en_i),
    .wr_en_i   (tlb_wr_en_i),
    .fonr_i    (tlb_fonr_i),
    .fonw_i    (tlb_fonw_i),
    .mchk_i    (mchk_c),
    .kind_o    (kind_c),
    .st_o      (st_c),
    .ev_o      (ev_c)
  );

  // Next-state
  logic            valid_d, valid_q;
  logic [PA_W-1:0] pa_d, pa_q;
  fault_e          kind_d, kind_q;
  logic [ST_W-1:0] st_d, st_q;
  logic            unc_d, unc_q;
  evt_t            ev_d, ev_q;

  always_comb begin
    valid_d = req_i;
    ev_d    = req_i ? ev_c : '0;
    pa_d    = pa_q;
    kind_d  = kind_q;
    st_d    = st_q;
    unc_d   = unc_q;
    if (req_i) begin
      pa_d   = pa_c;
      kind_d = kind_c;
      st_d   = st_c;
      unc_d  = unc_c && (kind_c == FK_NONE);
    end
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pa_q    <= '0;
      kind_q  <= FK_NONE;
      st_q    <= '0;
      unc_q   <= 1'b0;
      ev_q    <= '0;
    end else begin
      valid_q <= valid_d;
      pa_q    <= pa_d;
      kind_q  <= kind_d;
      st_q    <= st_d;
      unc_q   <= unc_d;
      ev_q    <= ev_d;
    end
  end

  assign valid_o      = valid_q;
  assign pa_o         = pa_q;
  assign fault_o      = kind_q;
  assign status_o     = st_q;
  assign uncached_o   = unc_q;
  assign ev_rd_hit_o  = ev_q.rd_hit;
  assign ev_rd_miss_o = ev_q.rd_miss;
  assign ev_rd_viol_o = ev_q.rd_viol;
  assign ev_wr_hit_o  = ev_q.wr_hit;
  assign ev_wr_miss_o = ev_q.wr_miss;
  assign ev_wr_viol_o = ev_q.wr_viol;

  logic [5:0] ev_bus;
  assign ev_bus = {ev_rd_hit_o, ev_rd_miss_o, ev_rd_viol_o,
                   ev_wr_hit_o, ev_wr_miss_o, ev_wr_viol_o};

  p_valid_after_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  p_idle_no_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);
  p_event_onehot_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ev_bus));
  p_event_needs_valid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev_bus) |-> valid_o);
  p_unc_field_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncached_o |-> (pa_o[UNC_BIT] && pa_o[CLR_HI:CLR_LO] == '0));
  p_unc_no_fault_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncached_o |-> fault_o == 3'd0);
  p_miss_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (fault_o == 3'd3 || fault_o == 3'd4)) |-> status_o[ST_MISS]);
  p_fon_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fault_o == 3'd5) |-> (!status_o[ST_ACV] && !status_o[ST_MISS]));
  p_mchk_clean_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fault_o == 3'd6) |-> status_o == '0);
endmodule

// File: tb/data_xlate_chk_bench.sv
module data_xlate_chk_bench;

  typedef struct packed {
    logic [7:0]  rq;
    logic [63:0] va;
    logic [1:0]  sz;
    logic        wr, ph, als, pv, pt;
    logic [1:0]  cm, am;
    logic        hit;
    logic [31:0] ppn;
    logic [3:0]  rde, wre;
    logic        fr, fw;
    logic [43:0] xpa;
    logic        cpa;
    logic [2:0]  xk;
    logic [4:0]  xs;
    logic        xu;
    logic [5:0]  xev;
  } vec_t;

  localparam int NV = 21;
  // fields: rq va sz wr ph als pv pt cm am hit ppn rde wre fr fw xpa cpa xk xs xu xev
  localparam vec_t TBL [NV] = '{
    // R8 read hit kernel
    '{8'd8, 64'h0000_0000_0001_2345, 2'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1, 32'h123, 4'b0001,4'b0000, 1'b0,1'b0, 44'h0_0024_6345, 1'b1, 3'd0, 5'b00000, 1'b0, 6'b100000},
    // R8 write hit user
    '{8'd8, 64'h0000_0000_0000_4008, 2'd3, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd3,2'd0, 1'b1, 32'h10, 4'b0000,4'b1000, 1'b0,1'b0, 44'h0_0002_0008, 1'b1, 3'd0, 5'b00000, 1'b0, 6'b000100},
    // R8 read violation carries fault-on-read flag
    '{8'd8, 64'h0000_0000_0001_2345, 2'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd3,2'd0, 1'b1, 32'h123, 4'b0001,4'b0000, 1'b1,1'b0, 44'h0, 1'b0, 3'd2, 5'b01010, 1'b0, 6'b001000},
    // R8 write violation supervisor
    '{8'd8, 64'h0000_0000_0000_4008, 2'd3, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd2,2'd0, 1'b1, 32'h10, 4'b1111,4'b1011, 1'b0,1'b0, 44'h0, 1'b0, 3'd2, 5'b00011, 1'b0, 6'b000001},
    // R9 fault-on-read
    '{8'd9, 64'h0000_0000_0001_2345, 2'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1, 32'h123, 4'b0001,4'b0000, 1'b1,1'b0, 44'h0, 1'b0, 3'd5, 5'b01000, 1'b0, 6'b001000},
    // R9 fault-on-write
    '{8'd9, 64'h0000_0000_0000_4008, 2'd3, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1, 32'h10, 4'b0000,4'b0001, 1'b1,1'b1, 44'h0, 1'b0, 3'd5, 5'b10001, 1'b0, 6'b000001},
    // R7 read miss, normal
    '{8'd7, 64'h0000_0000_0001_2345, 2'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0, 32'h0, 4'b0001,4'b0000, 1'b0,1'b0, 44'h0, 1'b0, 3'd3, 5'b00100, 1'b0, 6'b010000},
    // R7 write miss, PTE fetch
    '{8'd7, 64'h0000_0000_0000_4008, 2'd3, 1'b1,1'b0,1'b0,1'b0,1'b1, 2'd0,2'd0, 1'b0, 32'h0, 4'b0000,4'b0001, 1'b0,1'b0, 44'h0, 1'b0, 3'd4, 5'b00101, 1'b0, 6'b000010},
    // R2 misaligned write
    '{8'd2, 64'h0000_0000_0000_4004, 2'd3, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1, 32'h10, 4'b0000,4'b0001, 1'b0,1'b0, 44'h0, 1'b0, 3'd1, 5'b00001, 1'b0, 6'b000000},
    // R2 misaligned read in physical mode
    '{8'd2, 64'h0000_0000_0000_0001, 2'd1, 1'b0,1'b1,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0, 32'h0, 4'b0000,4'b0000, 1'b0,1'b0, 44'h0, 1'b0, 3'd1, 5'b00000, 1'b0, 6'b000000},
    // R4 physical pass-through
    '{8'd4, 64'h0000_0000_1234_5678, 2'd2, 1'b0,1'b1,1'b0,1'b0,1'b0, 2'd3,2'd0, 1'b0, 32'h0, 4'b0000,4'b0000, 1'b0,1'b0, 44'h0_1234_5678, 1'b1, 3'd0, 5'b00000, 1'b0, 6'b000000},
    // R10 physical address out of range
    '{8'd10, 64'h0000_1000_0000_0000, 2'd0, 1'b0,1'b1,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0, 32'h0, 4'b0000,4'b0000, 1'b0,1'b0, 44'h0, 1'b0, 3'd6, 5'b00000, 1'b0, 6'b000000},
    // R10 page frame too large, still a read hit (R12)
    '{8'd10, 64'h0000_0000_0000_0000, 2'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1, 32'h8000_0000, 4'b0001,4'b0000, 1'b0,1'b0, 44'h0, 1'b0, 3'd6, 5'b00000, 1'b0, 6'b100000},
    // R11 physical uncacheable, field cleared
    '{8'd11, 64'h0000_08FF_FFFF_FFF0, 2'd3, 1'b0,1'b1,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0, 32'h0, 4'b0000,4'b0000, 1'b0,1'b0, 44'h807_FFFF_FFF0, 1'b1, 3'd0, 5'b00000, 1'b1, 6'b000000},
    // R6 window with bit 40 set, becomes uncacheable
    '{8'd6, 64'h0000_FD00_0000_1000, 2'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0, 32'h0, 4'b0000,4'b0000, 1'b0,1'b0, 44'h800_0000_1000, 1'b1, 3'd0, 5'b00000, 1'b1, 6'b000000},
    // R6 window with bit 40 clear
    '{8'd6, 64'h0000_FC12_3456_7890, 2'd3, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0, 32'h0, 4'b0000,4'b0000, 1'b0,1'b0, 44'h012_3456_7890, 1'b1, 3'd0, 5'b00000, 1'b0, 6'b000000},
    // R5 window from user mode
    '{8'd5, 64'h0000_FC12_3456_7890, 2'd3, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd3,2'd0, 1'b0, 32'h0, 4'b0000,4'b0000, 1'b0,1'b0, 44'h0, 1'b0, 3'd2, 5'b00011, 1'b0, 6'b000001},
    // R3 privileged PC with alternate user mode
    '{8'd3, 64'h0000_0000_0001_2345, 2'd0, 1'b0,1'b0,1'b1,1'b1,1'b0, 2'd0,2'd3, 1'b1, 32'h123, 4'b0001,4'b0000, 1'b0,1'b0, 44'h0, 1'b0, 3'd2, 5'b00010, 1'b0, 6'b001000},
    // R3 privileged PC without alternate: kernel
    '{8'd3, 64'h0000_0000_0001_2345, 2'd0, 1'b0,1'b0,1'b0,1'b1,1'b0, 2'd3,2'd3, 1'b1, 32'h123, 4'b0001,4'b0000, 1'b0,1'b0, 44'h0_0024_6345, 1'b1, 3'd0, 5'b00000, 1'b0, 6'b100000},
    // R5 window uses current mode, not alternate
    '{8'd5, 64'h0000_FC12_3456_7890, 2'd3, 1'b0,1'b0,1'b1,1'b1,1'b0, 2'd0,2'd3, 1'b0, 32'h0, 4'b0000,4'b0000, 1'b0,1'b0, 44'h012_3456_7890, 1'b1, 3'd0, 5'b00000, 1'b0, 6'b000000},
    // R4 physical mode ignores lookup result
    '{8'd4, 64'h0000_0000_0000_2000, 2'd0, 1'b0,1'b1,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1, 32'h55, 4'b0000,4'b0000, 1'b0,1'b0, 44'h0_0000_2000, 1'b1, 3'd0, 5'b00000, 1'b0, 6'b000000}
  };

  logic        clk, rst_n, req;
  logic [63:0] va;
  logic [1:0]  sz, cm, am;
  logic        wr, ph, als, pv, pt, hit, fr, fw;
  logic [31:0] ppn;
  logic [3:0]  rde, wre;
  logic        valid;
  logic [43:0] pa;
  logic [2:0]  fault;
  logic [4:0]  status;
  logic        unc;
  logic        e_rh, e_rm, e_rv, e_wh, e_wm, e_wv;

  int total = 0;
  int bad   = 0;

  data_xlate_chk u_data_xlate_chk (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .va_i(va), .size_i(sz),
    .write_i(wr), .phys_i(ph), .alt_sel_i(als), .priv_pc_i(pv),
    .pte_fetch_i(pt), .cur_mode_i(cm), .alt_mode_i(am), .tlb_hit_i(hit),
    .tlb_ppn_i(ppn), .tlb_rd_en_i(rde), .tlb_wr_en_i(wre),
    .tlb_fonr_i(fr), .tlb_fonw_i(fw), .valid_o(valid), .pa_o(pa),
    .fault_o(fault), .status_o(status), .uncached_o(unc),
    .ev_rd_hit_o(e_rh), .ev_rd_miss_o(e_rm), .ev_rd_viol_o(e_rv),
    .ev_wr_hit_o(e_wh), .ev_wr_miss_o(e_wm), .ev_wr_viol_o(e_wv)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input int rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req = 1'b1; va = v.va; sz = v.sz; wr = v.wr; ph = v.ph; als = v.als;
    pv = v.pv; pt = v.pt; cm = v.cm; am = v.am; hit = v.hit; ppn = v.ppn;
    rde = v.rde; wre = v.wre; fr = v.fr; fw = v.fw;
  endtask

  function automatic logic [5:0] evs();
    return {e_rh, e_rm, e_rv, e_wh, e_wm, e_wv};
  endfunction

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; va = '0; sz = '0; wr = 1'b0; ph = 1'b0;
    als = 1'b0; pv = 1'b0; pt = 1'b0; cm = '0; am = '0; hit = 1'b0;
    ppn = '0; rde = '0; wre = '0; fr = 1'b0; fw = 1'b0;
    repeat (3) @(negedge clk);
    // R1 and R12: reset state
    chk(1, "valid in reset", 64'(valid), 64'd0);
    chk(12, "events in reset", 64'(evs()), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(1, "valid idle after reset", 64'(valid), 64'd0);

    // Vector table, back to back
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      chk(1, "valid", 64'(valid), 64'd1);
      chk(int'(TBL[i].rq), "fault kind", 64'(fault), 64'(TBL[i].xk));
      chk(int'(TBL[i].rq), "status", 64'(status), 64'(TBL[i].xs));
      chk(int'(TBL[i].rq), "uncached", 64'(unc), 64'(TBL[i].xu));
      chk(12, "events", 64'(evs()), 64'(TBL[i].xev));
      if (TBL[i].cpa) chk(int'(TBL[i].rq), "pa", 64'(pa), 64'(TBL[i].xpa));
    end

    // R1, R12: strobe low gives no result and no pulses next cycle
    req = 1'b0;
    @(negedge clk);
    chk(1, "valid after idle", 64'(valid), 64'd0);
    chk(12, "events after idle", 64'(evs()), 64'd0);

    // R1: single request between idles, result one cycle later only
    drive(TBL[1]);
    @(negedge clk);
    req = 1'b0;
    chk(1, "single req valid", 64'(valid), 64'd1);
    chk(8, "single req pa", 64'(pa), 64'h20008);
    chk(12, "single req write hit", 64'(evs()), 64'b000100);
    @(negedge clk);
    chk(1, "valid drops", 64'(valid), 64'd0);
    chk(12, "pulse is one cycle", 64'(evs()), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule